// File: doc/BRIEF.md
# Memory ECC Fault Injection Unit

This unit sits in the write-data path of the memory controller, between the source of write data and the memory interface. It corrupts chosen write data on purpose, so that the ECC correction and detection logic downstream can be exercised. Write data arrives as cache-line bursts of eight beats. Each beat is a 72-bit codeword made of eighteen 4-bit device lanes. When the unit is armed, it XORs two programmable 16-bit patterns into two device lanes, each chosen by its own pointer. This happens only in the half or halves of the cache line that are selected.

Every channel has its own three registers, its own arming state and its own data path. The channels share nothing except the write strobe of the register port, which is steered to one channel by a channel index. The injection parameters are copied into working state only at the moment the enable bit goes from 0 to 1. After that, writes to the registers leave an armed injection untouched. When the unit is disarmed, data flows through combinationally, with no added cycle.

Top module: `ecc_fault_inject`

## Requirements
- R1: After reset every channel is disarmed and `wdata_out` equals `wdata_in` on every cycle.
- R2: The register port decodes three addresses per channel.
  - Address 0 is mask register 0, with these fields:
    - bit 31: address-match enable
    - bits 29:28: half select
    - bit 27: enable
    - bits 25:10: pattern A
    - bits 9:5: pointer B
    - bits 4:0: pointer A
  - Address 1 is pattern B, in bits 15:0.
  - Address 2 is the control byte: start condition in bits 3:0, stop condition in bits 7:4.
  - A write to address 3 changes nothing.
- R3: The unit arms only when a write to address 0 sets bit 27 while the stored enable bit is 0, and the start condition is 4'b1011 at that moment. Any other start value leaves the unit disarmed.
- R4: The beat index counts 0 to 7 from the beat marked `beat_first`. Beats 0–3 form the lower half and beats 4–7 the upper half. Half select 01 corrupts the lower half, 10 the upper half and 11 both halves. A value of 00 corrupts nothing.
- R5: Lane p occupies codeword bits 4p+3:4p. In the k-th beat of a half, pattern bits 4k+3:4k are XORed into the lane.
- R6: Pattern A goes to the lane chosen by pointer A, and pattern B goes to the lane chosen by pointer B. When both pointers name the same lane, both nibbles are XORed into it.
- R7: A pointer value of 18 or above selects no lane.
- R8: A stop condition other than 4'b1011 is one-shot. Exactly one cache line is corrupted, and the unit then stays disarmed until the enable bit goes from 0 to 1 again.
- R9: Stop condition 4'b1011 corrupts every cache line while the unit is armed.
- R10: Half select, pointers and patterns, and the control byte, are captured when the unit arms. Later writes, including a further write with bit 27 set, do not alter an armed injection.
- R11: An arming write with bit 31 set leaves the unit disarmed, so nothing is injected.
- R12: The channels are independent. A write to one channel, or traffic on one channel, never changes another channel's output.
- R13: Corruption appears in the same cycle as its beat. A line is corrupted only if the unit is armed at its first beat. Writing bit 27 as 0 disarms the unit and stops corruption from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_chan | input | CHW | Channel that receives the write |
| reg_addr | input | 2 | Register address (0 mask 0, 1 pattern B, 2 control) |
| reg_wdata | input | 32 | Register write data |
| beat_valid | input | NCH | Beat present, one bit per channel |
| beat_first | input | NCH | First beat of a cache line, one bit per channel |
| wdata_in | input | NCH*72 | Incoming codewords, channel c in bits 72c+71:72c |
| wdata_out | output | NCH*72 | Codewords after injection, same layout |

## Verification
The data path has no register in it. The corruption of a beat is therefore due in the same cycle that the beat is presented. The bench drives inputs at the falling edge and compares both channels a quarter period later, before the next rising edge. A register write, whether it arms, disarms or stores a parameter, takes effect from the cycle after its rising edge. The bench's model applies each cycle's writes and beat progress right after the edge, and the comparison of the following cycle checks the result. A one-shot disarm at beat 7 shows up on the next line; the bench always sends that next line before it rewrites any register.

// File: rtl/efi_pkg.sv
package efi_pkg;
    localparam int LANE_W         = 4;
    localparam int LANES          = 18;
    localparam int CW_W           = LANES * LANE_W;
    localparam int PTR_W          = 5;
    localparam int PAT_W          = 16;
    localparam int REG_W          = 32;
    localparam int CTL_W          = 8;
    localparam int BEATS_PER_HALF = PAT_W / LANE_W;
    localparam int BEAT_W         = $clog2(2 * BEATS_PER_HALF);
    localparam int NIB_W          = $clog2(BEATS_PER_HALF);

    // mask register 0 field positions
    localparam int M0_AMATCH  = 31;
    localparam int M0_HALF_LO = 28;
    localparam int M0_EN      = 27;
    localparam int M0_PAT_LO  = 10;
    localparam int M0_PTRB_LO = 5;
    localparam int M0_PTRA_LO = 0;

    localparam logic [3:0] START_NOW  = 4'b1011;
    localparam logic [3:0] STOP_NEVER = 4'b1011;

    typedef enum logic [1:0] {
        A_MASK0 = 2'd0,
        A_PATB  = 2'd1,
        A_CTRL  = 2'd2,
        A_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [1:0]       half;
        logic [PTR_W-1:0] ptr_a;
        logic [PTR_W-1:0] ptr_b;
        logic [PAT_W-1:0] pat_a;
        logic [PAT_W-1:0] pat_b;
        logic             cont;
    } inj_cfg_t;
endpackage

// File: rtl/efi_regs.sv
module efi_regs
    import efi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             arm_pulse,
    output logic             dis_pulse,
    output logic             new_ok,
    output inj_cfg_t         new_cfg
);
    typedef struct packed {
        logic             en;
        logic [PAT_W-1:0] pat_b;
        logic [CTL_W-1:0] ctl;
    } regs_t;

    regs_t r_d, r_q;
    logic  m0_wr;
    logic  unused_bits;

    assign unused_bits = ^{wr_data[30], wr_data[26]};
    assign m0_wr       = wr_en && (wr_addr == A_MASK0);

    always_comb begin
        r_d = r_q;
        if (m0_wr)
            r_d.en = wr_data[M0_EN];
        if (wr_en && (wr_addr == A_PATB))
            r_d.pat_b = wr_data[PAT_W-1:0];
        if (wr_en && (wr_addr == A_CTRL))
            r_d.ctl = wr_data[CTL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        arm_pulse     = m0_wr && wr_data[M0_EN] && !r_q.en;
        dis_pulse     = m0_wr && !wr_data[M0_EN];
        new_cfg.half  = wr_data[M0_HALF_LO +: 2];
        new_cfg.ptr_a = wr_data[M0_PTRA_LO +: PTR_W];
        new_cfg.ptr_b = wr_data[M0_PTRB_LO +: PTR_W];
        new_cfg.pat_a = wr_data[M0_PAT_LO +: PAT_W];
        new_cfg.pat_b = r_q.pat_b;
        new_cfg.cont  = (r_q.ctl[7:4] == STOP_NEVER);
        new_ok        = (r_q.ctl[3:0] == START_NOW) && (|wr_data[M0_HALF_LO +: 2])
                        && !wr_data[M0_AMATCH];
    end

    // R2
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_NONE) |=> $stable(r_q));

    // R3
    arm_holds_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pulse |=> r_q.en);
endmodule

// File: rtl/efi_seq.sv
module efi_seq
    import efi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             arm_pulse,
    input  logic             dis_pulse,
    input  logic             new_ok,
    input  inj_cfg_t         new_cfg,
    output logic             inj_now,
    output logic [NIB_W-1:0] nib,
    output inj_cfg_t         cfg
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(2 * BEATS_PER_HALF - 1);

    typedef struct packed {
        logic              armed;
        logic              line;
        logic [BEAT_W-1:0] beat;
        inj_cfg_t          cfg;
    } seq_t;

    seq_t              s_d, s_q;
    logic [BEAT_W-1:0] cur_beat;
    logic              cur_line;

    always_comb begin
        s_d      = s_q;
        cur_beat = in_first ? '0 : s_q.beat;
        cur_line = in_first ? s_q.armed : s_q.line;
        if (in_valid) begin
            s_d.beat = BEAT_W'(cur_beat + 1'b1);
            s_d.line = cur_line;
            if (cur_beat == LAST_BEAT && cur_line && !s_q.cfg.cont)
                s_d.armed = 1'b0;
        end
        if (arm_pulse) begin
            s_d.cfg   = new_cfg;
            s_d.armed = new_ok;
        end else if (dis_pulse) begin
            s_d.armed = 1'b0;
            s_d.line  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign inj_now = in_valid && cur_line && s_q.cfg.half[cur_beat[BEAT_W-1]];
    assign nib     = cur_beat[NIB_W-1:0];
    assign cfg     = s_q.cfg;

    // R8
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_line && cur_beat == LAST_BEAT && !s_q.cfg.cont && !arm_pulse)
        |=> !s_q.armed);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_pulse |=> $stable(s_q.cfg));

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.armed) |-> $past(arm_pulse));
endmodule

// File: rtl/efi_lane_xor.sv
module efi_lane_xor
    import efi_pkg::*;
(
    input  inj_cfg_t         cfg,
    input  logic [NIB_W-1:0] nib,
    output logic [CW_W-1:0]  xor_vec
);
    logic [LANE_W-1:0] nib_a, nib_b;

    assign nib_a = cfg.pat_a[nib*LANE_W +: LANE_W];
    assign nib_b = cfg.pat_b[nib*LANE_W +: LANE_W];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign xor_vec[l*LANE_W +: LANE_W] =
            ((cfg.ptr_a == PTR_W'(l)) ? nib_a : '0) ^
            ((cfg.ptr_b == PTR_W'(l)) ? nib_b : '0);
    end
endmodule

// File: rtl/efi_chan.sv
module efi_chan
    import efi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [CW_W-1:0]  data_in,
    output logic [CW_W-1:0]  data_out
);
    logic             arm_pulse, dis_pulse, new_ok, inj_now;
    inj_cfg_t         new_cfg, cfg;
    logic [NIB_W-1:0] nib;
    logic [CW_W-1:0]  xv;

    efi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .arm_pulse(arm_pulse), .dis_pulse(dis_pulse), .new_ok(new_ok), .new_cfg(new_cfg)
    );

    efi_seq u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .arm_pulse(arm_pulse), .dis_pulse(dis_pulse), .new_ok(new_ok), .new_cfg(new_cfg),
        .inj_now(inj_now), .nib(nib), .cfg(cfg)
    );

    efi_lane_xor u_xor (.cfg(cfg), .nib(nib), .xor_vec(xv));

    assign data_out = data_in ^ (inj_now ? xv : '0);

    // R13
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_now |-> data_out == data_in);
endmodule

// File: rtl/ecc_fault_inject.sv
module ecc_fault_inject
    import efi_pkg::*;
#(
    parameter  int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [CHW-1:0]      reg_chan,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic [NCH-1:0]      beat_valid,
    input  logic [NCH-1:0]      beat_first,
    input  logic [NCH*CW_W-1:0] wdata_in,
    output logic [NCH*CW_W-1:0] wdata_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic wr_here;
        assign wr_here = reg_wr && (reg_chan == CHW'(c));

        efi_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_here), .wr_addr(reg_addr), .wr_data(reg_wdata),
            .in_valid(beat_valid[c]), .in_first(beat_first[c]),
            .data_in(wdata_in[c*CW_W +: CW_W]),
            .data_out(wdata_out[c*CW_W +: CW_W])
        );
    end
endmodule

// File: tb/tb_ecc_fault_inject.sv
module tb_ecc_fault_inject;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 2;
    localparam int CW  = 72;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr;
    logic [0:0]        reg_chan;
    logic [1:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic [NCH-1:0]    bvalid, bfirst;
    logic [NCH*CW-1:0] din, dout;

    always #10 clk = ~clk;

    ecc_fault_inject #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_chan(reg_chan),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .beat_valid(bvalid),
        .beat_first(bfirst), .wdata_in(din), .wdata_out(dout)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state, one slot per channel
    bit          m_en[NCH];
    logic [15:0] m_patb[NCH];
    logic [7:0]  m_ctl[NCH];
    bit          m_arm[NCH];
    bit          m_line[NCH];
    int          m_beat[NCH];
    int          c_half[NCH], c_pa[NCH], c_pb[NCH];
    logic [15:0] c_pata[NCH], c_patb[NCH];
    bit          c_cont[NCH];

    function automatic logic [CW-1:0] model_out(int c);
        int b, n;
        bit il;
        logic [CW-1:0] x;
        b  = bfirst[c] ? 0 : m_beat[c];
        il = bfirst[c] ? m_arm[c] : m_line[c];
        x  = '0;
        if (bvalid[c] && il && (((c_half[c] >> (b / 4)) & 1) == 1)) begin
            n = b % 4;
            for (int l = 0; l < 18; l++) begin
                if (c_pa[c] == l) x[4*l +: 4] = x[4*l +: 4] ^ c_pata[c][4*n +: 4];
                if (c_pb[c] == l) x[4*l +: 4] = x[4*l +: 4] ^ c_patb[c][4*n +: 4];
            end
        end
        return din[c*CW +: CW] ^ x;
    endfunction

    task automatic model_tick();
        for (int c = 0; c < NCH; c++) begin
            int b;
            bit il;
            b  = bfirst[c] ? 0 : m_beat[c];
            il = bfirst[c] ? m_arm[c] : m_line[c];
            if (bvalid[c]) begin
                m_beat[c] = (b + 1) % 8;
                m_line[c] = il;
                if (b == 7 && il && !c_cont[c]) m_arm[c] = 1'b0;
            end
            if (reg_wr && int'(reg_chan) == c) begin
                case (reg_addr)
                    2'd0: begin
                        if (reg_wdata[27] && !m_en[c]) begin
                            c_half[c] = int'(reg_wdata[29:28]);
                            c_pa[c]   = int'(reg_wdata[4:0]);
                            c_pb[c]   = int'(reg_wdata[9:5]);
                            c_pata[c] = reg_wdata[25:10];
                            c_patb[c] = m_patb[c];
                            c_cont[c] = (m_ctl[c][7:4] == 4'hB);
                            m_arm[c]  = (m_ctl[c][3:0] == 4'hB) && (reg_wdata[29:28] != 2'b00)
                                        && !reg_wdata[31];
                        end else if (!reg_wdata[27]) begin
                            m_arm[c]  = 1'b0;
                            m_line[c] = 1'b0;
                        end
                        m_en[c] = reg_wdata[27];
                    end
                    2'd1: m_patb[c] = reg_wdata[15:0];
                    2'd2: m_ctl[c]  = reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step();
        #5;
        for (int c = 0; c < NCH; c++) begin
            logic [CW-1:0] exp_v;
            exp_v = model_out(c);
            n_chk++;
            if (dout[c*CW +: CW] !== exp_v) begin
                n_bad++;
                $display("FAIL %s ch%0d: got %h expected %h", cur_req, c,
                         dout[c*CW +: CW], exp_v);
            end
        end
        @(posedge clk);
        #1;
        model_tick();
        @(negedge clk);
    endtask

    task automatic set_idle();
        reg_wr = 1'b0; reg_chan = '0; reg_addr = '0; reg_wdata = '0;
        bvalid = '0; bfirst = '0;
        for (int c = 0; c < NCH; c++) din[c*CW +: CW] = 72'({$urandom, $urandom, $urandom});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            set_idle();
            step();
        end
    endtask

    task automatic wr(int ch, int a, logic [31:0] d);
        set_idle();
        reg_wr = 1'b1; reg_chan = 1'(ch); reg_addr = 2'(a); reg_wdata = d;
        step();
    endtask

    task automatic line(logic [1:0] chm, bit w = 1'b0, int ch = 0, int a = 0,
                        logic [31:0] d = '0);
        for (int b = 0; b < 8; b++) begin
            set_idle();
            bvalid = chm;
            if (b == 0) begin
                bfirst = chm;
                if (w) begin
                    reg_wr = 1'b1; reg_chan = 1'(ch); reg_addr = 2'(a); reg_wdata = d;
                end
            end
            step();
        end
        idle(1);
    endtask

    function automatic logic [31:0] m0(bit am, int half, logic [15:0] pa, int pb, int p,
                                       bit en = 1'b1);
        return {am, 1'b0, 2'(half), en, 1'b0, pa, 5'(pb), 5'(p)};
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog R1: run did not end, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_patb[c] = '0; m_ctl[c] = '0; m_arm[c] = 0; m_line[c] = 0;
            m_beat[c] = 0; c_half[c] = 0; c_pa[c] = 0; c_pb[c] = 0;
            c_pata[c] = '0; c_patb[c] = '0; c_cont[c] = 0;
        end
        set_idle();
        // R1 reset state, pass-through during and after reset
        cur_req = "R1";
        step(); step(); step();
        rst_n = 1'b1;
        idle(2);
        line(2'b11);

        // R5 R6 R9 continuous, both halves, two lanes
        cur_req = "R9";
        wr(0, 1, 32'h0000_BEEF);
        wr(0, 2, 32'h0000_00BB);
        wr(0, 0, m0(0, 3, 16'h1234, 7, 2));
        line(2'b01);
        cur_req = "R5";
        line(2'b01);

        // R13 disable, then arm on the same cycle as a first beat
        cur_req = "R13";
        wr(0, 0, 32'h0);
        line(2'b01);
        line(2'b01, 1'b1, 0, 0, m0(0, 3, 16'hA5C3, 17, 0));
        line(2'b01);
        // disable in the middle of a line
        for (int b = 0; b < 8; b++) begin
            set_idle(); bvalid = 2'b01; bfirst = (b == 0) ? 2'b01 : 2'b00;
            if (b == 3) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0; end
            step();
        end
        idle(1);

        // R8 one-shot lower half, then upper half
        cur_req = "R8";
        wr(0, 2, 32'h0000_00AB);
        wr(0, 0, m0(0, 1, 16'hFFFF, 3, 4));
        line(2'b01);
        line(2'b01);
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h0000_00CB);
        wr(0, 0, m0(0, 2, 16'h8421, 9, 10));
        line(2'b01);
        line(2'b01);

        // R4 half select 00
        cur_req = "R4";
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h0000_00BB);
        wr(0, 0, m0(0, 0, 16'hFFFF, 1, 1));
        line(2'b01);

        // R7 out-of-range pointers
        cur_req = "R7";
        wr(0, 0, 32'h0);
        wr(0, 0, m0(0, 3, 16'hFFFF, 31, 18));
        line(2'b01);

        // R6 both pointers on one lane
        cur_req = "R6";
        wr(0, 0, 32'h0);
        wr(0, 1, 32'h0000_0F0F);
        wr(0, 0, m0(0, 3, 16'h00FF, 5, 5));
        line(2'b01);

        // R3 start values that never start
        cur_req = "R3";
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h0000_00BA);
        wr(0, 0, m0(0, 3, 16'hFFFF, 2, 3));
        line(2'b01);
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h0000_00B5);
        wr(0, 0, m0(0, 3, 16'hFFFF, 2, 3));
        line(2'b01);

        // R11 address-match bit blocks injection
        cur_req = "R11";
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h0000_00BB);
        wr(0, 0, m0(1, 3, 16'hFFFF, 2, 3));
        line(2'b01);

        // R10 parameters latched at arming
        cur_req = "R10";
        wr(0, 0, 32'h0);
        wr(0, 1, 32'h0000_1357);
        wr(0, 0, m0(0, 3, 16'h2468, 11, 12));
        wr(0, 1, 32'h0000_FFFF);
        wr(0, 2, 32'h0000_00AA);
        wr(0, 0, m0(0, 1, 16'hFFFF, 0, 1));
        line(2'b01);
        line(2'b01);

        // R2 unused address, then traffic
        cur_req = "R2";
        wr(0, 3, 32'hFFFF_FFFF);
        line(2'b01);
        wr(0, 0, 32'h0);
        wr(0, 3, 32'hFFFF_FFFF);
        line(2'b01);

        // R12 channels run independently
        cur_req = "R12";
        wr(0, 2, 32'h0000_00BB);
        wr(0, 0, m0(0, 3, 16'h0F0F, 8, 6));
        wr(1, 1, 32'h0000_7777);
        wr(1, 2, 32'h0000_00AB);
        wr(1, 0, m0(0, 2, 16'h9999, 13, 16));
        line(2'b11);
        line(2'b11);
        wr(1, 0, 32'h0);
        line(2'b11);

        idle(2);
        summary();
        $finish;
    end
endmodule